// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical memory address from a 16-bit segment value and a 16-bit offset. It holds four segment registers: code, data, stack and extra. Software-visible logic outside the block loads them through a single write port. For each access request the block picks one of the four registers from the kind of access and an optional override. It appends four zero bits to the chosen value and adds the offset. The result is registered and presented with a valid strobe one clock later.

The physical space is 1 MB. Each segment reaches at most 64 KB above its base, and segments may overlap. A sum beyond the top of memory drops its carry and wraps to address zero. A register write and a request in the same cycle see the register's old contents. The new value serves requests from the next cycle on.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pa_valid` is 0 and `pa` is 0, and all four segment registers hold 0.
- R2: The physical address of a request equals the selected segment value times 16 plus the offset. For example, segment 0xFF00 with offset 0x0FFF gives 0xFFFFF.
- R3: When the sum exceeds 0xFFFFF, bit 20 is dropped and the address wraps. For example, segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R4: A fetch request (`req_kind` = 0) always uses the code segment (register index 0) and ignores `ovr_en`.
- R5: A data request (`req_kind` = 1) uses the data segment (index 1). When `ovr_en` is 1 it uses the segment indexed by `ovr_sel` instead.
- R6: A stack request (`req_kind` = 2) uses the stack segment (index 2). When `ovr_en` is 1 it uses the segment indexed by `ovr_sel` instead.
- R7: A string-destination request (`req_kind` = 3) always uses the extra segment (index 3) and ignores `ovr_en`.
- R8: A write (`wr_en` = 1) stores `wr_data` into the register indexed by `wr_sel` at the clock edge. A request in the same cycle uses the old value, and a request in the following cycle uses the new one.
- R9: `pa_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. In other cycles it is 0, and `pa` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Index of the register to write (0 code, 1 data, 2 stack, 3 extra) |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind (0 fetch, 1 data, 2 stack, 3 string destination) |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Segment index used when the override applies |
| offset | input | 16 | Offset within the segment |
| pa_valid | output | 1 | Physical address valid, one cycle after a request |
| pa | output | 20 | Registered physical address |

## Verification
On every cycle the assertions check the one-cycle valid latency, that fetches track the code register and string destinations track the extra register whatever the override says, and that a write lands in the addressed register at the next edge. The bench's reference model shows what no single property covers. This includes the old-value rule for a write and a request in the same cycle, wrap past the top of memory, the exact top address, overrides on data and stack accesses toward each register, and `pa` holding its value across idle cycles.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NSEG)-1:0]     wr_sel,
  input  logic [SEG_W-1:0]            wr_data,
  input  logic                        req_valid,
  input  logic [1:0]                  req_kind,
  input  logic                        ovr_en,
  input  logic [$clog2(NSEG)-1:0]     ovr_sel,
  input  logic [OFS_W-1:0]            offset,
  output logic                        pa_valid,
  output logic [SEG_W+SHIFT-1:0]      pa
);
  localparam int PA_W  = SEG_W + SHIFT;
  localparam int SEL_W = $clog2(NSEG);
  localparam logic [SEL_W-1:0] CS_I = SEL_W'(0);
  localparam logic [SEL_W-1:0] DS_I = SEL_W'(1);
  localparam logic [SEL_W-1:0] SS_I = SEL_W'(2);
  localparam logic [SEL_W-1:0] ES_I = SEL_W'(3);

  logic [SEG_W-1:0] seg_q [NSEG];
  logic [SEL_W-1:0] sel;
  logic [PA_W-1:0]  base, sum;

  always_comb begin
    case (req_kind)
      2'd0:    sel = CS_I;
      2'd2:    sel = ovr_en ? ovr_sel : SS_I;
      2'd3:    sel = ES_I;
      default: sel = ovr_en ? ovr_sel : DS_I;
    endcase
  end

  assign base = {seg_q[sel], {SHIFT{1'b0}}};
  assign sum  = base + PA_W'(offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
    end else if (wr_en) begin
      seg_q[wr_sel] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_valid <= 1'b0;
      pa       <= '0;
    end else begin
      pa_valid <= req_valid;
      if (req_valid) pa <= sum;
    end
  end

  a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pa_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !pa_valid);
  a_r4_fetch_uses_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=>
      pa == PA_W'({$past(seg_q[CS_I]), {SHIFT{1'b0}}} + PA_W'($past(offset))));
  a_r7_strdst_uses_extra: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=>
      pa == PA_W'({$past(seg_q[ES_I]), {SHIFT{1'b0}}} + PA_W'($past(offset))));
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, req_valid = 0, ovr_en = 0;
  logic [1:0]  wr_sel = 0, req_kind = 0, ovr_sel = 0;
  logic [15:0] wr_data = 0, offset = 0;
  logic        pa_valid;
  logic [19:0] pa;

  int checks = 0, fails = 0;
  bit done = 0;
  int seg_m [4];
  int exp_pa = 0;
  bit exp_v = 0;

  always #10 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .offset(offset), .pa_valid(pa_valid), .pa(pa));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (pa_valid !== exp_v || pa !== 20'(exp_pa)) begin
      fails++;
      $display("FAIL %s: valid=%0b pa=%05h expected valid=%0b pa=%05h",
               tag, pa_valid, pa, exp_v, 20'(exp_pa));
    end
  endtask

  task automatic step(bit we, int ws, int wd, bit rv, int rk, bit ov, int os, int off,
                      string tag);
    int s;
    wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd);
    req_valid = rv; req_kind = 2'(rk); ovr_en = ov; ovr_sel = 2'(os); offset = 16'(off);
    exp_v = rv;
    if (rv) begin
      case (rk)
        0: s = 0;
        1: s = ov ? os : 1;
        2: s = ov ? os : 2;
        default: s = 3;
      endcase
      exp_pa = (seg_m[s] * 16 + off) % 1048576;
    end
    if (we) seg_m[ws] = wd;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) seg_m[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1;
    step(0,0,0, 0,0,0,0,0, "R1 after reset idle");
    step(0,0,0, 1,0,0,0,16'h1234, "R1 code reg zero after reset");
    step(0,0,0, 1,3,0,0,16'h00AB, "R1 extra reg zero after reset");
    step(1,0,16'h0100, 0,0,0,0,0, "R8 write code");
    step(1,2,16'h0CF0, 1,0,0,0,16'h0010, "R4 fetch uses code");
    step(1,3,16'h0FF0, 1,2,0,0,16'h0FFE, "R6 stack default");
    step(1,1,16'hB200, 1,1,0,0,16'h0004, "R8 same-cycle write uses old value");
    step(0,0,0, 1,1,0,0,16'h0004, "R8 next cycle uses new value");
    step(0,0,0, 1,1,1,3,16'h0020, "R5 data override to extra");
    step(0,0,0, 1,1,1,0,16'h0020, "R5 data override to code");
    step(0,0,0, 1,2,1,1,16'h0300, "R6 stack override to data");
    step(0,0,0, 1,0,1,2,16'h0040, "R4 fetch ignores override");
    step(0,0,0, 1,3,1,1,16'h0050, "R7 string dest ignores override");
    step(0,0,0, 1,3,0,0,16'h0050, "R7 string dest uses extra");
    step(0,0,0, 0,1,0,0,16'h7777, "R9 idle holds pa");
    step(0,0,0, 0,3,1,2,16'h1111, "R9 second idle");
    step(1,0,16'hFF00, 0,0,0,0,0, "R9 idle during write");
    step(0,0,0, 1,0,0,0,16'h0FFF, "R2 top address");
    step(1,0,16'hFFFF, 0,0,0,0,0, "R8 write code max");
    step(0,0,0, 1,0,0,0,16'hFFFF, "R3 wrap past top");
    step(0,0,0, 1,0,0,0,16'h0010, "R3 wrap to zero");
    begin
      int lcg = 32'h1F2E3D;
      for (int n = 0; n < 400; n++) begin
        int a, b;
        lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
        a = lcg;
        lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
        b = lcg;
        step((a >> 3) % 3 == 0, (a >> 5) & 3, b & 16'hFFFF,
             (a >> 8) % 4 != 0, (a >> 10) & 3, (a >> 12) & 1, (a >> 13) & 3,
             (b >> 16) & 16'hFFFF, "R2 random mix");
      end
    end
    finish_run();
  end
endmodule